// File: doc/BRIEF.md
# Dual-timebase timer/counter unit

A 16-bit timer/counter held in two byte registers, high and low, that software can load one at a time and read at any time. A function bit in the shared mode byte sets the role. As a timer the unit counts a prescaled system clock. As a counter it counts falling edges on an external pin. The timer tick runs at one of two rates. The legacy rate is one tick per twelve system clocks. The fast rate is one tick per four system clocks. A per-unit time-base bit picks the rate and can be changed while the unit runs.

Timing comes from a machine cycle of four system clocks. Its third phase is the only point at which counting updates the registers. Its fourth phase is the only point at which the pin is sampled. Two mode bits choose how the count is arranged: a 13-bit count with a 5-bit prescaler in the low byte, a full 16-bit count, an 8-bit count with auto-reload, or two separate 8-bit counts. Every overflow sets a sticky flag, which holds until it is cleared.

Top module: `tmr_unit`

## Requirements
- R1: After reset both count bytes read 0x00, both overflow flags read 0 and the time-base bit reads 0, which selects the divide-by-12 rate.
- R2: A machine cycle is 4 clocks. Apart from register writes, the count changes only at the update phase. With the fast rate selected in 16-bit mode it rises by exactly 10 over any 40 clocks.
- R3: With the time-base bit at 0 the timer tick comes once every 12 clocks, so the count rises by exactly 4 over any 48 clocks.
- R4: In counter role the pin is sampled once per machine cycle. A count occurs only when one sample is 1 and the next is 0. The increment lands at the update phase of the machine cycle after the one that saw the low sample, so a pin that changes faster than the sampling gives at most one count.
- R5: For unit index 0, bits [3:0] of the mode byte configure the unit. Bit 2 selects the role: 0 means timer and 1 means counter. Bits [1:0] select the mode. Bit 3 and the other unit's nibble have no effect. In counter role, internal ticks do not count.
- R6: Mode 0 (bits [1:0] = 0): bits [4:0] of the low byte form a divide-by-32 prescaler that feeds the high byte, and low-byte bits [7:5] are left unchanged. The flag is set when the high byte wraps from 0xFF.
- R7: Mode 1: the two bytes form one 16-bit count with the low byte as the LSBs. The flag is set when the count wraps from 0xFFFF to 0x0000.
- R8: Mode 2: the low byte counts. When it steps from 0xFF it loads the high byte instead and sets the flag. The high byte is not changed by counting.
- R9: Mode 3: the low byte counts by the selected role under the main run enable and sets the main flag when it wraps. The high byte counts timer ticks under its own run enable and sets the second flag when it wraps.
- R10: While a run enable is 0, the part it gates does not count.
- R11: A write to either byte in a cycle cancels all counting in that cycle. The written byte takes the written data.
- R12: An overflow flag stays at 1 until its clear input is driven. If a set and a clear arrive in the same cycle, the set wins.
- R13: Writing the time-base bit takes effect at the next clock, and the new value can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_byte | input | 8 | Shared mode byte; this unit decodes its own nibble |
| turbo_we | input | 1 | Write strobe for the time-base bit |
| turbo_wd | input | 1 | Time-base bit value: 1 = divide-by-4, 0 = divide-by-12 |
| run_en | input | 1 | Run enable for the main count |
| run_hi_en | input | 1 | Run enable for the high byte in split mode |
| ext_pin | input | 1 | External count input, synchronous to clk |
| wr_lo | input | 1 | Write strobe for the low byte |
| wr_hi | input | 1 | Write strobe for the high byte |
| wr_data | input | 8 | Write data for either byte |
| flag_clr | input | 1 | Clears the main overflow flag |
| flag_hi_clr | input | 1 | Clears the split-mode high-byte flag |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Main overflow flag, sticky |
| ovf_hi_flag | output | 1 | High-byte overflow flag in split mode, sticky |
| turbo_q | output | 1 | Current time-base bit |

## Verification
The bench measures count growth over windows of exactly 40 and 48 clocks. A phase generator with an off-by-one period, or a divider that ignores the time-base bit, shows up there as a wrong delta. It drives the pin with slow pulses and with toggling faster than the machine cycle. A detector that reacts to any low level, or that samples every clock, over-counts there. Directed loads just below each wrap point check the prescaler carry and the reload source. They also check that only the split-mode high byte raises the second flag, so a mode decoder with swapped arms gives wrong byte values. A random phase compares every cycle against a bench model, which catches a write that fails to cancel the tick and a clear that overrides a simultaneous set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MD_PRE13   = 2'd0,
    MD_FULL16  = 2'd1,
    MD_RELOAD8 = 2'd2,
    MD_SPLIT8  = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      ext_sel;
    tmr_mode_e mode;
  } tmr_ctl_t;

endpackage

// File: rtl/tmr_phase_gen.sv
module tmr_phase_gen #(
  parameter int MC_CLKS  = 4,
  parameter int SLOW_MCS = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic upd_stb,
  output logic smp_stb,
  output logic tick_fast,
  output logic tick_slow
);

  localparam int PH_W   = $clog2(MC_CLKS);
  localparam int DV_W   = $clog2(SLOW_MCS);
  localparam int UPD_PH = MC_CLKS - 2;
  localparam int SMP_PH = MC_CLKS - 1;

  logic [PH_W-1:0] phase_q, phase_d;
  logic [DV_W-1:0] div_q, div_d;

  assign upd_stb   = (phase_q == PH_W'(UPD_PH));
  assign smp_stb   = (phase_q == PH_W'(SMP_PH));
  assign tick_fast = upd_stb;
  assign tick_slow = upd_stb & (div_q == '0);

  always_comb begin
    phase_d = smp_stb ? '0 : phase_q + PH_W'(1);
    div_d   = div_q;
    if (smp_stb) begin
      div_d = (div_q == DV_W'(SLOW_MCS - 1)) ? '0 : div_q + DV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      div_q   <= '0;
    end else begin
      phase_q <= phase_d;
      div_q   <= div_d;
    end
  end

endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_stb,
  input  logic upd_stb,
  input  logic pin_i,
  output logic edge_tick
);

  logic samp_q, samp_d;
  logic pend_q, pend_d;

  assign edge_tick = upd_stb & pend_q;

  always_comb begin
    samp_d = samp_q;
    pend_d = pend_q;
    if (upd_stb) begin
      pend_d = 1'b0;
    end
    if (smp_stb) begin
      samp_d = pin_i;
      pend_d = samp_q & ~pin_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode,
  input  logic              lo_tick,
  input  logic              hi_tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              flag_clr,
  input  logic              flag_hi_clr,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              flag_q,
  output logic              flag_hi_q
);

  localparam int CW = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_d, hi_d;
  logic              flag_d, flag_hi_d;
  logic              inc_lo, inc_hi, set_lo, set_hi;

  assign inc_lo = lo_tick & ~(wr_lo | wr_hi);
  assign inc_hi = hi_tick & ~(wr_lo | wr_hi);

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    set_lo = 1'b0;
    set_hi = 1'b0;
    unique case (mode)
      MD_PRE13: begin
        if (inc_lo) begin
          if (&lo_q[PRE_W-1:0]) begin
            lo_d[PRE_W-1:0] = '0;
            hi_d            = hi_q + BYTE_W'(1);
            set_lo          = &hi_q;
          end else begin
            lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + PRE_W'(1);
          end
        end
      end
      MD_FULL16: begin
        if (inc_lo) begin
          {hi_d, lo_d} = {hi_q, lo_q} + CW'(1);
          set_lo       = &{hi_q, lo_q};
        end
      end
      MD_RELOAD8: begin
        if (inc_lo) begin
          if (&lo_q) begin
            lo_d   = hi_q;
            set_lo = 1'b1;
          end else begin
            lo_d = lo_q + BYTE_W'(1);
          end
        end
      end
      MD_SPLIT8: begin
        if (inc_lo) begin
          lo_d   = lo_q + BYTE_W'(1);
          set_lo = &lo_q;
        end
        if (inc_hi) begin
          hi_d   = hi_q + BYTE_W'(1);
          set_hi = &hi_q;
        end
      end
      default: begin
        lo_d = lo_q;
      end
    endcase
    if (wr_lo) lo_d = wr_data;
    if (wr_hi) hi_d = wr_data;
    flag_d    = set_lo | (flag_q & ~flag_clr);
    flag_hi_d = set_hi | (flag_hi_q & ~flag_hi_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      hi_q      <= '0;
      flag_q    <= 1'b0;
      flag_hi_q <= 1'b0;
    end else begin
      lo_q      <= lo_d;
      hi_q      <= hi_d;
      flag_q    <= flag_d;
      flag_hi_q <= flag_hi_d;
    end
  end

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int UNIT_IDX = 0,
  parameter int BYTE_W   = 8,
  parameter int PRE_W    = 5,
  parameter int MC_CLKS  = 4,
  parameter int SLOW_MCS = 3,
  parameter int RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        mode_byte,
  input  logic              turbo_we,
  input  logic              turbo_wd,
  input  logic              run_en,
  input  logic              run_hi_en,
  input  logic              ext_pin,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              flag_clr,
  input  logic              flag_hi_clr,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ovf_flag,
  output logic              ovf_hi_flag,
  output logic              turbo_q
);

  // reset: asserted at once, released through a short flop chain
  logic [RST_SYNC-1:0] rs_q;
  logic                core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[RST_SYNC-2:0], 1'b1};
    end
  end
  assign core_rst_n = rs_q[RST_SYNC-1];

  // per-unit nibble of the shared mode byte
  logic [3:0] nib;
  logic       cfg_unused;
  generate
    if (UNIT_IDX == 0) begin : g_nib_lo
      assign nib = mode_byte[3:0];
    end else begin : g_nib_hi
      assign nib = mode_byte[7:4];
    end
  endgenerate
  assign cfg_unused = ^mode_byte;

  tmr_ctl_t  ctl;
  tmr_mode_e cur_mode;
  assign ctl.ext_sel = nib[2];
  assign ctl.mode    = tmr_mode_e'(nib[1:0]);
  assign cur_mode    = ctl.mode;

  // time-base select bit
  logic turbo_d;
  always_comb begin
    turbo_d = turbo_q;
    if (turbo_we) turbo_d = turbo_wd;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      turbo_q <= 1'b0;
    end else begin
      turbo_q <= turbo_d;
    end
  end

  logic upd_stb, smp_stb, tick_fast, tick_slow, edge_tick;

  tmr_phase_gen #(
    .MC_CLKS (MC_CLKS),
    .SLOW_MCS(SLOW_MCS)
  ) u_phase (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .upd_stb  (upd_stb),
    .smp_stb  (smp_stb),
    .tick_fast(tick_fast),
    .tick_slow(tick_slow)
  );

  tmr_edge_det u_edge (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .smp_stb  (smp_stb),
    .upd_stb  (upd_stb),
    .pin_i    (ext_pin),
    .edge_tick(edge_tick)
  );

  logic tick_timer, lo_tick, hi_tick;
  assign tick_timer = turbo_q ? tick_fast : tick_slow;
  assign lo_tick    = run_en & (ctl.ext_sel ? edge_tick : tick_timer);
  assign hi_tick    = run_hi_en & tick_timer & (ctl.mode == MD_SPLIT8);

  tmr_count_core #(
    .BYTE_W(BYTE_W),
    .PRE_W (PRE_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .mode       (ctl.mode),
    .lo_tick    (lo_tick),
    .hi_tick    (hi_tick),
    .wr_lo      (wr_lo),
    .wr_hi      (wr_hi),
    .wr_data    (wr_data),
    .flag_clr   (flag_clr),
    .flag_hi_clr(flag_hi_clr),
    .lo_q       (cnt_lo),
    .hi_q       (cnt_hi),
    .flag_q     (ovf_flag),
    .flag_hi_q  (ovf_hi_flag)
  );

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_stb,
  input logic              run_en,
  input logic              run_hi_en,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic [BYTE_W-1:0] wr_data,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic              ovf_flag,
  input logic              flag_clr,
  input logic [1:0]        mode_i
);

  AST_UPD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> ##4 upd_stb); // R2

  AST_HOLD_OFF_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_stb && !wr_lo && !wr_hi) |=> $stable({cnt_hi, cnt_lo})); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !run_hi_en && !wr_lo && !wr_hi) |=> $stable({cnt_hi, cnt_lo})); // R10

  AST_WRITE_WINS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_lo == $past(wr_data))); // R11

  AST_WRITE_WINS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (cnt_hi == $past(wr_data))); // R11

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag); // R12

  AST_FLAG_AT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(upd_stb)); // R12

  AST_RELOAD_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2 && !wr_hi) |=> $stable(cnt_hi)); // R8

endmodule

bind tmr_unit tmr_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (core_rst_n),
  .upd_stb  (upd_stb),
  .run_en   (run_en),
  .run_hi_en(run_hi_en),
  .wr_lo    (wr_lo),
  .wr_hi    (wr_hi),
  .wr_data  (wr_data),
  .cnt_lo   (cnt_lo),
  .cnt_hi   (cnt_hi),
  .ovf_flag (ovf_flag),
  .flag_clr (flag_clr),
  .mode_i   (cur_mode)
);

// File: tb/tmr_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_unit_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic [7:0] mode_byte;
  logic       turbo_we, turbo_wd, run_en, run_hi_en, ext_pin;
  logic       wr_lo, wr_hi, flag_clr, flag_hi_clr;
  logic [7:0] wr_data;
  logic [7:0] cnt_lo, cnt_hi;
  logic       ovf_flag, ovf_hi_flag, turbo_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  tmr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .mode_byte(mode_byte),
    .turbo_we(turbo_we), .turbo_wd(turbo_wd),
    .run_en(run_en), .run_hi_en(run_hi_en), .ext_pin(ext_pin),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .flag_clr(flag_clr), .flag_hi_clr(flag_hi_clr),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .ovf_flag(ovf_flag), .ovf_hi_flag(ovf_hi_flag), .turbo_q(turbo_q)
  );

  // ---------------- bench model built from the requirements ----------------
  logic       m_r1, m_r2, m_s, m_pend, m_f, m_fh, m_tb;
  logic [1:0] m_ph, m_d3;
  logic [7:0] m_lo, m_hi;

  // returns {set_main, set_hi, hi, lo}
  function automatic logic [17:0] step(input logic [1:0] md, input logic [7:0] lo,
                                       input logic [7:0] hi, input logic inc,
                                       input logic inch);
    logic sf = 1'b0;
    logic sh = 1'b0;
    case (md)
      2'd0: if (inc) begin
        if (lo[4:0] == 5'h1f) begin
          lo[4:0] = 5'h00; sf = (hi == 8'hff); hi = hi + 8'd1;
        end else lo[4:0] = lo[4:0] + 5'd1;
      end
      2'd1: if (inc) begin
        sf = (lo == 8'hff) && (hi == 8'hff); {hi, lo} = {hi, lo} + 16'd1;
      end
      2'd2: if (inc) begin
        if (lo == 8'hff) begin lo = hi; sf = 1'b1; end else lo = lo + 8'd1;
      end
      default: begin
        if (inc)  begin sf = (lo == 8'hff); lo = lo + 8'd1; end
        if (inch) begin sh = (hi == 8'hff); hi = hi + 8'd1; end
      end
    endcase
    return {sf, sh, hi, lo};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_r1 <= 1'b0; m_r2 <= 1'b0; end
    else begin m_r1 <= 1'b1; m_r2 <= m_r1; end
  end

  always @(posedge clk or negedge m_r2) begin : model_p
    logic        c3, c4, tt, ext, anyw, inc, inch;
    logic [17:0] r;
    if (!m_r2) begin
      m_ph <= 2'd0; m_d3 <= 2'd0; m_s <= 1'b0; m_pend <= 1'b0;
      m_lo <= 8'h00; m_hi <= 8'h00; m_f <= 1'b0; m_fh <= 1'b0; m_tb <= 1'b0;
    end else begin
      c3   = (m_ph == 2'd2);
      c4   = (m_ph == 2'd3);
      tt   = c3 && (m_tb || m_d3 == 2'd0);
      ext  = mode_byte[2];
      anyw = wr_lo | wr_hi;
      inc  = run_en && !anyw && (ext ? (c3 && m_pend) : tt);
      inch = run_hi_en && !anyw && tt && (mode_byte[1:0] == 2'd3);
      r    = step(mode_byte[1:0], m_lo, m_hi, inc, inch);
      m_lo <= wr_lo ? wr_data : r[7:0];
      m_hi <= wr_hi ? wr_data : r[15:8];
      m_f  <= r[17] | (m_f & ~flag_clr);
      m_fh <= r[16] | (m_fh & ~flag_hi_clr);
      m_ph <= m_ph + 2'd1;
      if (c4) begin
        m_d3   <= (m_d3 == 2'd2) ? 2'd0 : m_d3 + 2'd1;
        m_s    <= ext_pin;
        m_pend <= m_s & ~ext_pin;
      end else if (c3) begin
        m_pend <= 1'b0;
      end
      if (turbo_we) m_tb <= turbo_wd;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(negedge clk);
    chk(tag, {13'd0, cnt_hi, cnt_lo, ovf_flag, ovf_hi_flag, turbo_q},
             {13'd0, m_hi, m_lo, m_f, m_fh, m_tb});
  endtask

  task automatic cycn(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic load(input logic [7:0] lo, input logic [7:0] hi);
    wr_lo = 1'b1; wr_data = lo; cyc("R11 load lo");
    wr_lo = 1'b0; wr_hi = 1'b1; wr_data = hi; cyc("R11 load hi");
    wr_hi = 1'b0;
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1; flag_hi_clr = 1'b1; cyc("R12 clear");
    flag_clr = 1'b0; flag_hi_clr = 1'b0;
  endtask

  task automatic wait_flag(input bit hi_sel, input string tag);
    for (int i = 0; i < 2000; i++) begin
      if (hi_sel ? ovf_hi_flag : ovf_flag) break;
      cyc(tag);
    end
  endtask

  task automatic set_turbo(input logic v);
    turbo_we = 1'b1; turbo_wd = v; cyc("R13 time-base write");
    turbo_we = 1'b0;
  endtask

  function automatic logic [15:0] cnt16();
    return {cnt_hi, cnt_lo};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #760000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin : main_p
    logic [15:0] v0;
    logic [7:0]  h0;
    int          hold;
    void'($urandom(32'd4242));
    rst_n = 1'b0; mode_byte = 8'h00; turbo_we = 1'b0; turbo_wd = 1'b0;
    run_en = 1'b0; run_hi_en = 1'b0; ext_pin = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0;
    wr_data = 8'h00; flag_clr = 1'b0; flag_hi_clr = 1'b0;

    repeat (5) @(negedge clk);
    chk("R1 reset state", {cnt_hi, cnt_lo, ovf_flag, ovf_hi_flag, turbo_q}, 32'd0);
    rst_n = 1'b1;
    cycn("R1 after release", 4);
    chk("R1 time-base bit clear", turbo_q, 32'd0);

    // R13 / R2: fast rate in 16-bit mode
    mode_byte = 8'h01;
    set_turbo(1'b1);
    chk("R13 time-base readback", turbo_q, 32'd1);
    run_en = 1'b1;
    cyc("R2 model");
    v0 = cnt16();
    cycn("R2 model", 40);
    chk("R2 fast rate 10 per 40 clocks", 32'(16'(cnt16() - v0)), 32'd10);

    // R3: legacy rate
    set_turbo(1'b0);
    v0 = cnt16();
    cycn("R3 model", 48);
    chk("R3 legacy rate 4 per 48 clocks", 32'(16'(cnt16() - v0)), 32'd4);

    // R5: other unit's function bit ignored
    set_turbo(1'b1);
    mode_byte = 8'h49;
    cyc("R5 model");
    v0 = cnt16();
    cycn("R5 model", 40);
    chk("R5 foreign bits ignored", 32'(16'(cnt16() - v0)), 32'd10);

    // R5: counter role ignores internal ticks
    mode_byte = 8'h05; ext_pin = 1'b1;
    cycn("R5 model", 8);
    v0 = cnt16();
    cycn("R5 model", 40);
    chk("R5 counter role no internal ticks", 32'(16'(cnt16() - v0)), 32'd0);

    // R4: slow pulses count exactly once each
    v0 = cnt16();
    for (int p = 0; p < 5; p++) begin
      ext_pin = 1'b0; cycn("R4 model", 8);
      ext_pin = 1'b1; cycn("R4 model", 8);
    end
    cycn("R4 model", 8);
    chk("R4 one count per falling edge", 32'(16'(cnt16() - v0)), 32'd5);

    // R4: toggling faster than sampling
    v0 = cnt16();
    for (int t = 0; t < 40; t++) begin
      ext_pin = ~ext_pin; cyc("R4 model");
    end
    cycn("R4 model", 8);
    chk("R4 fast toggle at most one count", 32'(16'(cnt16() - v0) <= 16'd1), 32'd1);
    ext_pin = 1'b1;

    // R10: run disabled
    mode_byte = 8'h01; run_en = 1'b0;
    cyc("R10 model");
    v0 = cnt16();
    cycn("R10 model", 40);
    chk("R10 no count when stopped", 32'(16'(cnt16() - v0)), 32'd0);

    // R11: writes hold off counting
    run_en = 1'b1; h0 = cnt_hi;
    wr_lo = 1'b1; wr_data = 8'h33;
    cycn("R11 model", 20);
    wr_lo = 1'b0;
    chk("R11 write beats tick lo", cnt_lo, 32'h33);
    chk("R11 write beats tick hi", cnt_hi, 32'(h0));

    // R7: 16-bit wrap
    run_en = 1'b0; load(8'hff, 8'hff); clear_flags();
    run_en = 1'b1; wait_flag(1'b0, "R7 model");
    chk("R7 16-bit wrap value", 32'(cnt16()), 32'h0000);
    chk("R7 16-bit wrap flag", ovf_flag, 32'd1);

    // R12: sticky and clear
    run_en = 1'b0;
    cycn("R12 model", 20);
    chk("R12 flag sticky", ovf_flag, 32'd1);
    clear_flags();
    chk("R12 flag cleared", ovf_flag, 32'd0);

    // R6: 13-bit mode
    mode_byte = 8'h00; load(8'hff, 8'hff); clear_flags();
    run_en = 1'b1; wait_flag(1'b0, "R6 model");
    chk("R6 prescaler wrap keeps upper bits", cnt_lo, 32'he0);
    chk("R6 high byte wrap", cnt_hi, 32'h00);

    // R8: reload mode
    run_en = 1'b0; mode_byte = 8'h02; load(8'hfe, 8'ha5); clear_flags();
    run_en = 1'b1; wait_flag(1'b0, "R8 model");
    chk("R8 reload from high byte", cnt_lo, 32'ha5);
    chk("R8 high byte untouched", cnt_hi, 32'ha5);

    // R9: split mode, high byte on its own enable
    run_en = 1'b0; mode_byte = 8'h03; load(8'h10, 8'hff); clear_flags();
    run_hi_en = 1'b1; wait_flag(1'b1, "R9 model");
    chk("R9 split high wrap", cnt_hi, 32'h00);
    chk("R9 split low untouched", cnt_lo, 32'h10);
    chk("R9 main flag untouched", ovf_flag, 32'd0);

    // random phase against the model
    hold = 0;
    for (int k = 0; k < 4000; k++) begin
      if (k % 250 == 0) mode_byte = 8'($urandom);
      run_en      = ($urandom % 8) != 0;
      run_hi_en   = ($urandom % 4) != 0;
      wr_lo       = ($urandom % 16) == 0;
      wr_hi       = ($urandom % 24) == 0;
      wr_data     = 8'($urandom);
      if (($urandom % 4) == 0) wr_data = 8'hff;
      flag_clr    = ($urandom % 16) == 0;
      flag_hi_clr = ($urandom % 16) == 0;
      turbo_we    = ($urandom % 64) == 0;
      turbo_wd    = 1'($urandom);
      if (hold == 0) begin
        ext_pin = ~ext_pin;
        hold = int'($urandom % 12);
      end else hold--;
      cyc("R4 R6 R7 R8 R9 R11 R12 random model");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule